// File: doc/BRIEF.md
# Inclusive Shared-Cache Directory Line Controller

This block is the coherence controller for one line of one bank of an inclusive shared second-level cache. The bank doubles as the on-chip directory for a set of private first-level caches. For its line the controller keeps a stable state, a one-bit-per-client sharer vector, the index of the exclusive owner and a dirty flag. It decides how each demand request is answered. A request can get data from the bank, or be forwarded to the client that owns the line. It can also trigger invalidates to the other sharers, or start a fetch from memory.

After the controller grants a request, the line stays blocked until the requestor confirms completion with an unblock or an exclusive unblock. A line owned by a client is treated as stale in the bank. A read to such a line completes only after two messages have arrived: the owner's writeback data and the reader's unblock. They may come in either order or in the same cycle. Any demand request that reaches a line in a fetch or blocked state is rejected with a one-cycle recycle pulse, so that the surrounding queue can retry it later.

All responses are registered and appear the cycle after the event that caused them. Tag matching, data storage, eviction and the network are outside this block.

Top module: `dirline_ctrl`

## Requirements
- R1: After reset the line is not present: permission code 0, empty sharer vector, owner 0, dirty 0, and no output pulse.
- R2: Permission tracks the state. Code 0 means not present, 1 means shared (read-only), 2 means modified in the bank (read-write), 3 means owned by a client (stale in the bank), and 4 means busy, which covers every fetch and blocked state.
- R3: Request type codes are 0 read, 1 instruction read, 2 exclusive read, 3 upgrade and 4 writeback; codes 5 to 7 are ignored. A read, instruction read or exclusive read to a not-present line pulses fetch_valid and makes the line busy. The two read kinds set the sharer vector to the requestor alone; an exclusive read clears it.
- R4: On memory data, a pending read sends exclusive data and a pending exclusive read sends non-exclusive data; both go to the recorded requestor with ack count 0 and leave the line blocked for an exclusive unblock. A pending instruction read sends shared data and leaves the line blocked for an unblock. The dirty flag takes the response's dirty bit, and a data response that comes from a client is ignored while a fetch is pending.
- R5: In shared state, a read or instruction read returns non-exclusive data with ack count 0 and adds the requestor to the sharers. An exclusive read returns data with ack count equal to minus the sharer count, plus one if the requestor is a sharer. It also invalidates every other sharer; inv_valid is pulsed only when that mask is non-empty.
- R6: An upgrade from a current sharer, in shared state, returns no data. It pulses ack_valid to the requestor with a count of one minus the sharer count and invalidates the other sharers. An upgrade from a non-sharer is handled exactly as an exclusive read.
- R7: A writeback from the owner of a client-owned line moves the line to bank-modified. It clears the sharers, takes the request's dirty bit and pulses wback_valid to the requestor. Every other writeback is consumed with no output and no change of state.
- R8: In bank-modified state, a read returns exclusive data and an exclusive read returns non-exclusive data; both leave the line blocked for an exclusive unblock. An instruction read returns shared data, adds the requestor as a sharer and leaves the line blocked for an unblock.
- R9: In client-owned state, an exclusive read or upgrade is forwarded to the owner with fwd_excl 1. A read or instruction read is forwarded with fwd_excl 0. The read then returns to shared state only after the owner's data (which sets dirty) and the reader's unblock (which adds the reader as a sharer) have both arrived, in either order or in the same cycle.
- R10: An exclusive unblock on a blocked line makes the sender the owner and the only sharer, and moves the line to client-owned state.
- R11: A plain unblock on a line blocked after a shared grant returns it to shared state with the sharers unchanged.
- R12: A read, instruction read, exclusive read or upgrade that reaches a line in any fetch or blocked state pulses recycle and changes nothing.
- R13: A request presented with req_hit low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_hit | input | 1 | Request addresses this line |
| req_type | input | 3 | Request type code (R3) |
| req_id | input | ID_W | Requesting client |
| req_dirty | input | 1 | Dirty bit carried by a writeback |
| rsp_valid | input | 1 | Data response present |
| rsp_mem | input | 1 | 1: response from memory, 0: from a client |
| rsp_dirty | input | 1 | Dirty bit of the response data |
| unblk_valid | input | 1 | Unblock present |
| unblk_excl | input | 1 | Unblock is exclusive |
| unblk_id | input | ID_W | Client sending the unblock |
| data_valid | output | 1 | Data response pulse |
| data_excl | output | 1 | Data grants exclusive permission |
| data_dest | output | ID_W | Destination client of the data |
| data_ack | output | ACK_W | Signed ack count carried with the data |
| ack_valid | output | 1 | Upgrade acknowledge pulse |
| ack_dest | output | ID_W | Destination of the acknowledge |
| ack_cnt | output | ACK_W | Signed ack count of the acknowledge |
| fwd_valid | output | 1 | Forward to owner pulse |
| fwd_excl | output | 1 | Forwarded request is exclusive |
| fwd_dest | output | ID_W | Owner receiving the forward |
| fwd_req | output | ID_W | Original requestor |
| inv_valid | output | 1 | Invalidate pulse |
| inv_mask | output | NUM_L1 | Clients to invalidate |
| fetch_valid | output | 1 | Memory fetch pulse |
| wback_valid | output | 1 | Writeback acknowledge pulse |
| wback_dest | output | ID_W | Client receiving the writeback acknowledge |
| recycle | output | 1 | Request was rejected and must be retried |
| perm | output | 3 | Permission code (R2) |
| sharers | output | NUM_L1 | Sharer vector, bit i for client i |
| owner | output | ID_W | Exclusive owner index |
| dirty | output | 1 | Line dirty flag |

## Verification
The hardest situation to create from the ports is the read to a client-owned line, because the owner's data and the reader's unblock can arrive in either order or together. Reaching it takes a memory fetch, an exclusive grant and an exclusive unblock before the read. The stimulus runs this path three times, once for each arrival order, and re-enters client ownership through a shared-state exclusive read and through a writeback followed by a bank-modified read. The not-present entry paths for instruction reads and exclusive reads can only be reached again through a second and a third reset.

// File: rtl/dirline_pkg.sv
package dirline_pkg;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_SHRD       = 4'd1,
        ST_L2MOD      = 4'd2,
        ST_L1OWN      = 4'd3,
        ST_FETCH_RD   = 4'd4,
        ST_FETCH_IRD  = 4'd5,
        ST_FETCH_WR   = 4'd6,
        ST_HOLD_SHRD  = 4'd7,
        ST_HOLD_EXCL  = 4'd8,
        ST_WAIT_BOTH  = 4'd9,
        ST_WAIT_DATA  = 4'd10,
        ST_WAIT_UNBLK = 4'd11
    } line_st_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_READ,
        EV_IREAD,
        EV_WRITE,
        EV_UPGRADE,
        EV_WB,
        EV_WB_STALE
    } req_ev_e;

    localparam logic [2:0] RT_READ    = 3'd0;
    localparam logic [2:0] RT_IREAD   = 3'd1;
    localparam logic [2:0] RT_WRITE   = 3'd2;
    localparam logic [2:0] RT_UPGRADE = 3'd3;
    localparam logic [2:0] RT_WB      = 3'd4;

    localparam logic [2:0] PERM_NONE  = 3'd0;
    localparam logic [2:0] PERM_RO    = 3'd1;
    localparam logic [2:0] PERM_RW    = 3'd2;
    localparam logic [2:0] PERM_STALE = 3'd3;
    localparam logic [2:0] PERM_BUSY  = 3'd4;

    function automatic logic [2:0] perm_of(line_st_e s);
        case (s)
            ST_IDLE:  return PERM_NONE;
            ST_SHRD:  return PERM_RO;
            ST_L2MOD: return PERM_RW;
            ST_L1OWN: return PERM_STALE;
            default:  return PERM_BUSY;
        endcase
    endfunction

    function automatic logic is_demand(req_ev_e e);
        return (e == EV_READ) || (e == EV_IREAD) || (e == EV_WRITE) || (e == EV_UPGRADE);
    endfunction

endpackage

// File: rtl/dirline_sharer_calc.sv
module dirline_sharer_calc #(
    parameter int NUM_L1 = 4,
    parameter int ID_W   = 2,
    parameter int CNT_W  = 3,
    parameter int ACK_W  = 4
) (
    input  logic [NUM_L1-1:0] shr_vec,
    input  logic [ID_W-1:0]   who,
    output logic              member,
    output logic [CNT_W-1:0]  count,
    output logic [NUM_L1-1:0] others,
    output logic [ACK_W-1:0]  data_ack,
    output logic [ACK_W-1:0]  upg_ack
);

    for (genvar g = 0; g < NUM_L1; g++) begin : g_mask
        assign others[g] = shr_vec[g] && (ID_W'(g) != who);
    end

    assign member = |(shr_vec ^ others);

    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_L1; i++) begin
            count = count + CNT_W'(shr_vec[i]);
        end
    end

    assign data_ack = ACK_W'(member) - ACK_W'(count);
    assign upg_ack  = ACK_W'(1) - ACK_W'(count);

endmodule

// File: rtl/dirline_req_decode.sv
module dirline_req_decode
    import dirline_pkg::*;
(
    input  logic       valid,
    input  logic       hit,
    input  logic [2:0] typ,
    input  logic       member,
    output req_ev_e    ev
);

    always_comb begin
        ev = EV_NONE;
        if (valid && hit) begin
            case (typ)
                RT_READ:    ev = EV_READ;
                RT_IREAD:   ev = EV_IREAD;
                RT_WRITE:   ev = EV_WRITE;
                RT_UPGRADE: ev = member ? EV_UPGRADE : EV_WRITE;
                RT_WB:      ev = member ? EV_WB : EV_WB_STALE;
                default:    ev = EV_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dirline_ctrl.sv
module dirline_ctrl
    import dirline_pkg::*;
#(
    parameter int NUM_L1 = 4,
    localparam int ID_W  = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1,
    localparam int CNT_W = $clog2(NUM_L1 + 1),
    localparam int ACK_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_hit,
    input  logic [2:0]        req_type,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_dirty,
    input  logic              rsp_valid,
    input  logic              rsp_mem,
    input  logic              rsp_dirty,
    input  logic              unblk_valid,
    input  logic              unblk_excl,
    input  logic [ID_W-1:0]   unblk_id,
    output logic              data_valid,
    output logic              data_excl,
    output logic [ID_W-1:0]   data_dest,
    output logic [ACK_W-1:0]  data_ack,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_dest,
    output logic [ACK_W-1:0]  ack_cnt,
    output logic              fwd_valid,
    output logic              fwd_excl,
    output logic [ID_W-1:0]   fwd_dest,
    output logic [ID_W-1:0]   fwd_req,
    output logic              inv_valid,
    output logic [NUM_L1-1:0] inv_mask,
    output logic              fetch_valid,
    output logic              wback_valid,
    output logic [ID_W-1:0]   wback_dest,
    output logic              recycle,
    output logic [2:0]        perm,
    output logic [NUM_L1-1:0] sharers,
    output logic [ID_W-1:0]   owner,
    output logic              dirty
);

    typedef struct packed {
        line_st_e          st;
        logic [NUM_L1-1:0] shr;
        logic [ID_W-1:0]   own;
        logic              dty;
        logic [ID_W-1:0]   pend;
        logic              dv;
        logic              dx;
        logic [ID_W-1:0]   dd;
        logic [ACK_W-1:0]  da;
        logic              av;
        logic [ID_W-1:0]   ad;
        logic [ACK_W-1:0]  ac;
        logic              fv;
        logic              fx;
        logic [ID_W-1:0]   fd;
        logic [ID_W-1:0]   fr;
        logic              iv;
        logic [NUM_L1-1:0] im;
        logic              mf;
        logic              wv;
        logic [ID_W-1:0]   wd;
        logic              rc;
    } line_regs_t;

    line_regs_t r_q, r_d;

    logic              req_member;
    logic [CNT_W-1:0]  shr_count;
    logic [NUM_L1-1:0] shr_others;
    logic [ACK_W-1:0]  ack_for_data;
    logic [ACK_W-1:0]  ack_for_upg;
    req_ev_e           ev;
    logic [NUM_L1-1:0] req_oh;
    logic [NUM_L1-1:0] unblk_oh;
    logic              mem_data;
    logic              l1_data;
    logic              plain_unblk;
    logic              excl_unblk;

    dirline_sharer_calc #(
        .NUM_L1 (NUM_L1),
        .ID_W   (ID_W),
        .CNT_W  (CNT_W),
        .ACK_W  (ACK_W)
    ) u_calc (
        .shr_vec  (r_q.shr),
        .who      (req_id),
        .member   (req_member),
        .count    (shr_count),
        .others   (shr_others),
        .data_ack (ack_for_data),
        .upg_ack  (ack_for_upg)
    );

    dirline_req_decode u_dec (
        .valid  (req_valid),
        .hit    (req_hit),
        .typ    (req_type),
        .member (req_member),
        .ev     (ev)
    );

    assign req_oh      = NUM_L1'(1) << req_id;
    assign unblk_oh    = NUM_L1'(1) << unblk_id;
    assign mem_data    = rsp_valid && rsp_mem;
    assign l1_data     = rsp_valid && !rsp_mem;
    assign plain_unblk = unblk_valid && !unblk_excl;
    assign excl_unblk  = unblk_valid && unblk_excl;

    always_comb begin
        r_d    = r_q;
        r_d.dv = 1'b0;
        r_d.dx = 1'b0;
        r_d.dd = '0;
        r_d.da = '0;
        r_d.av = 1'b0;
        r_d.ad = '0;
        r_d.ac = '0;
        r_d.fv = 1'b0;
        r_d.fx = 1'b0;
        r_d.fd = '0;
        r_d.fr = '0;
        r_d.iv = 1'b0;
        r_d.im = '0;
        r_d.mf = 1'b0;
        r_d.wv = 1'b0;
        r_d.wd = '0;
        r_d.rc = 1'b0;

        if (r_q.st >= ST_FETCH_RD && is_demand(ev)) begin
            r_d.rc = 1'b1;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (ev == EV_READ || ev == EV_IREAD) begin
                    r_d.st   = (ev == EV_READ) ? ST_FETCH_RD : ST_FETCH_IRD;
                    r_d.shr  = req_oh;
                    r_d.pend = req_id;
                    r_d.mf   = 1'b1;
                end else if (ev == EV_WRITE || ev == EV_UPGRADE) begin
                    r_d.st   = ST_FETCH_WR;
                    r_d.shr  = '0;
                    r_d.pend = req_id;
                    r_d.mf   = 1'b1;
                end
            end
            ST_FETCH_RD, ST_FETCH_IRD, ST_FETCH_WR: begin
                if (mem_data) begin
                    r_d.dty = rsp_dirty;
                    r_d.dv  = 1'b1;
                    r_d.dd  = r_q.pend;
                    r_d.dx  = (r_q.st == ST_FETCH_RD);
                    r_d.st  = (r_q.st == ST_FETCH_IRD) ? ST_HOLD_SHRD : ST_HOLD_EXCL;
                end
            end
            ST_SHRD: begin
                if (ev == EV_READ || ev == EV_IREAD) begin
                    r_d.dv  = 1'b1;
                    r_d.dd  = req_id;
                    r_d.shr = r_q.shr | req_oh;
                    r_d.st  = ST_HOLD_SHRD;
                end else if (ev == EV_WRITE) begin
                    r_d.dv = 1'b1;
                    r_d.dd = req_id;
                    r_d.da = ack_for_data;
                    r_d.iv = |shr_others;
                    r_d.im = shr_others;
                    r_d.st = ST_HOLD_SHRD;
                end else if (ev == EV_UPGRADE) begin
                    r_d.av = 1'b1;
                    r_d.ad = req_id;
                    r_d.ac = ack_for_upg;
                    r_d.iv = |shr_others;
                    r_d.im = shr_others;
                    r_d.st = ST_HOLD_SHRD;
                end
            end
            ST_L2MOD: begin
                if (ev == EV_READ || ev == EV_WRITE || ev == EV_UPGRADE) begin
                    r_d.dv = 1'b1;
                    r_d.dx = (ev == EV_READ);
                    r_d.dd = req_id;
                    r_d.da = ack_for_data;
                    r_d.st = ST_HOLD_EXCL;
                end else if (ev == EV_IREAD) begin
                    r_d.dv  = 1'b1;
                    r_d.dd  = req_id;
                    r_d.da  = ack_for_data;
                    r_d.shr = r_q.shr | req_oh;
                    r_d.st  = ST_HOLD_SHRD;
                end
            end
            ST_L1OWN: begin
                if (is_demand(ev)) begin
                    r_d.fv = 1'b1;
                    r_d.fx = (ev == EV_WRITE || ev == EV_UPGRADE);
                    r_d.fd = r_q.own;
                    r_d.fr = req_id;
                    r_d.st = (ev == EV_WRITE || ev == EV_UPGRADE) ? ST_HOLD_EXCL : ST_WAIT_BOTH;
                end else if (ev == EV_WB) begin
                    r_d.st  = ST_L2MOD;
                    r_d.shr = '0;
                    r_d.dty = req_dirty;
                    r_d.wv  = 1'b1;
                    r_d.wd  = req_id;
                end
            end
            ST_HOLD_SHRD, ST_HOLD_EXCL: begin
                if (excl_unblk) begin
                    r_d.st  = ST_L1OWN;
                    r_d.own = unblk_id;
                    r_d.shr = unblk_oh;
                end else if (plain_unblk && r_q.st == ST_HOLD_SHRD) begin
                    r_d.st = ST_SHRD;
                end
            end
            ST_WAIT_BOTH: begin
                if (plain_unblk) begin
                    r_d.shr = r_q.shr | unblk_oh;
                end
                if (l1_data) begin
                    r_d.dty = rsp_dirty;
                end
                if (plain_unblk && l1_data) begin
                    r_d.st = ST_SHRD;
                end else if (plain_unblk) begin
                    r_d.st = ST_WAIT_DATA;
                end else if (l1_data) begin
                    r_d.st = ST_WAIT_UNBLK;
                end
            end
            ST_WAIT_DATA: begin
                if (l1_data) begin
                    r_d.dty = rsp_dirty;
                    r_d.st  = ST_SHRD;
                end
            end
            ST_WAIT_UNBLK: begin
                if (plain_unblk) begin
                    r_d.shr = r_q.shr | unblk_oh;
                    r_d.st  = ST_SHRD;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_valid  = r_q.dv;
    assign data_excl   = r_q.dx;
    assign data_dest   = r_q.dd;
    assign data_ack    = r_q.da;
    assign ack_valid   = r_q.av;
    assign ack_dest    = r_q.ad;
    assign ack_cnt     = r_q.ac;
    assign fwd_valid   = r_q.fv;
    assign fwd_excl    = r_q.fx;
    assign fwd_dest    = r_q.fd;
    assign fwd_req     = r_q.fr;
    assign inv_valid   = r_q.iv;
    assign inv_mask    = r_q.im;
    assign fetch_valid = r_q.mf;
    assign wback_valid = r_q.wv;
    assign wback_dest  = r_q.wd;
    assign recycle     = r_q.rc;
    assign perm        = perm_of(r_q.st);
    assign sharers     = r_q.shr;
    assign owner       = r_q.own;
    assign dirty       = r_q.dty;

    // R12
    recycle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recycle |-> ($past(perm) == PERM_BUSY) && $stable(sharers));

    // R3
    fetch_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ($past(perm) == PERM_NONE) && (perm == PERM_BUSY));

    // R10
    excl_unblock_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (excl_unblk && (r_q.st == ST_HOLD_SHRD || r_q.st == ST_HOLD_EXCL))
        |=> (perm == PERM_STALE) && (owner == $past(unblk_id)) && ($countones(sharers) == 1));

    // R6
    upgrade_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> !data_valid && !fwd_valid && (perm == PERM_BUSY));

    // R5
    inv_skips_requestor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_mask != '0) && !inv_mask[$past(req_id)]);

    // R7
    wback_to_l2mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wback_valid |-> (perm == PERM_RW) && (sharers == '0) && ($past(perm) == PERM_STALE));

    // R12
    one_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_valid, ack_valid, fwd_valid, wback_valid, recycle, fetch_valid}));

endmodule

// File: tb/tb_dirline_ctrl.sv
module tb_dirline_ctrl;

    localparam int N = 4;

    localparam int M_IDLE = 0, M_SH = 1, M_MOD = 2, M_OWN = 3;
    localparam int M_FR = 4, M_FI = 5, M_FW = 6;
    localparam int M_BS = 7, M_BX = 8, M_W2 = 9, M_WD = 10, M_WU = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_hit = 0, req_dirty = 0;
    logic [2:0] req_type = 0;
    logic [1:0] req_id = 0;
    logic rsp_valid = 0, rsp_mem = 0, rsp_dirty = 0;
    logic unblk_valid = 0, unblk_excl = 0;
    logic [1:0] unblk_id = 0;

    logic data_valid, data_excl, ack_valid, fwd_valid, fwd_excl;
    logic inv_valid, fetch_valid, wback_valid, recycle, dirty;
    logic [1:0] data_dest, ack_dest, fwd_dest, fwd_req, wback_dest, owner;
    logic [3:0] data_ack, ack_cnt;
    logic [N-1:0] inv_mask, sharers;
    logic [2:0] perm;

    dirline_ctrl #(.NUM_L1(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_hit(req_hit), .req_type(req_type),
        .req_id(req_id), .req_dirty(req_dirty),
        .rsp_valid(rsp_valid), .rsp_mem(rsp_mem), .rsp_dirty(rsp_dirty),
        .unblk_valid(unblk_valid), .unblk_excl(unblk_excl), .unblk_id(unblk_id),
        .data_valid(data_valid), .data_excl(data_excl), .data_dest(data_dest),
        .data_ack(data_ack), .ack_valid(ack_valid), .ack_dest(ack_dest),
        .ack_cnt(ack_cnt), .fwd_valid(fwd_valid), .fwd_excl(fwd_excl),
        .fwd_dest(fwd_dest), .fwd_req(fwd_req), .inv_valid(inv_valid),
        .inv_mask(inv_mask), .fetch_valid(fetch_valid), .wback_valid(wback_valid),
        .wback_dest(wback_dest), .recycle(recycle), .perm(perm),
        .sharers(sharers), .owner(owner), .dirty(dirty)
    );

    always #10 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // reference model state
    int mst = M_IDLE;
    bit [N-1:0] msh = '0;
    int mown = 0, mpend = 0;
    bit mdty = 0;
    // expected pulses
    bit e_dv, e_dx, e_av, e_fv, e_fx, e_iv, e_mf, e_wv, e_rc;
    int e_dd, e_da, e_ad, e_ac, e_fd, e_fr, e_wd;
    bit [N-1:0] e_im;

    function automatic int perm_exp(int s);
        if (s == M_IDLE) return 0;
        if (s == M_SH) return 1;
        if (s == M_MOD) return 2;
        if (s == M_OWN) return 3;
        return 4;
    endfunction

    task automatic model_reset();
        mst = M_IDLE; msh = '0; mown = 0; mpend = 0; mdty = 0;
        {e_dv, e_dx, e_av, e_fv, e_fx, e_iv, e_mf, e_wv, e_rc} = '0;
        e_dd = 0; e_da = 0; e_ad = 0; e_ac = 0; e_fd = 0; e_fr = 0; e_wd = 0; e_im = '0;
    endtask

    task automatic model_step();
        int k, cnt, rid, uid;
        bit mem, cl, ub, ux, isshr, dem;
        bit [N-1:0] oth;
        {e_dv, e_dx, e_av, e_fv, e_fx, e_iv, e_mf, e_wv, e_rc} = '0;
        e_dd = 0; e_da = 0; e_ad = 0; e_ac = 0; e_fd = 0; e_fr = 0; e_wd = 0; e_im = '0;
        rid = int'(req_id); uid = int'(unblk_id);
        isshr = msh[rid];
        cnt = $countones(msh);
        oth = msh; oth[rid] = 1'b0;
        k = -1;
        if (req_valid && req_hit && req_type <= 3'd4) begin
            k = int'(req_type);
            if (k == 3 && !isshr) k = 2;
        end
        dem = (k >= 0 && k <= 3);
        mem = rsp_valid && rsp_mem;
        cl  = rsp_valid && !rsp_mem;
        ub  = unblk_valid && !unblk_excl;
        ux  = unblk_valid && unblk_excl;
        if (mst >= M_FR && dem) e_rc = 1;
        if (mst == M_IDLE) begin
            if (k == 0 || k == 1) begin
                mst = (k == 0) ? M_FR : M_FI; msh = '0; msh[rid] = 1; mpend = rid; e_mf = 1;
            end else if (k == 2 || k == 3) begin
                mst = M_FW; msh = '0; mpend = rid; e_mf = 1;
            end
        end else if (mst == M_FR || mst == M_FI || mst == M_FW) begin
            if (mem) begin
                mdty = rsp_dirty; e_dv = 1; e_dd = mpend; e_dx = (mst == M_FR);
                mst = (mst == M_FI) ? M_BS : M_BX;
            end
        end else if (mst == M_SH) begin
            if (k == 0 || k == 1) begin
                e_dv = 1; e_dd = rid; msh[rid] = 1; mst = M_BS;
            end else if (k == 2) begin
                e_dv = 1; e_dd = rid; e_da = (isshr ? 1 : 0) - cnt;
                e_iv = (oth != 0); e_im = oth; mst = M_BS;
            end else if (k == 3) begin
                e_av = 1; e_ad = rid; e_ac = 1 - cnt;
                e_iv = (oth != 0); e_im = oth; mst = M_BS;
            end
        end else if (mst == M_MOD) begin
            if (k == 0 || k == 2 || k == 3) begin
                e_dv = 1; e_dd = rid; e_dx = (k == 0); e_da = (isshr ? 1 : 0) - cnt; mst = M_BX;
            end else if (k == 1) begin
                e_dv = 1; e_dd = rid; e_da = (isshr ? 1 : 0) - cnt; msh[rid] = 1; mst = M_BS;
            end
        end else if (mst == M_OWN) begin
            if (dem) begin
                e_fv = 1; e_fd = mown; e_fr = rid; e_fx = (k >= 2);
                mst = (k >= 2) ? M_BX : M_W2;
            end else if (k == 4 && isshr) begin
                mst = M_MOD; msh = '0; mdty = req_dirty; e_wv = 1; e_wd = rid;
            end
        end else if (mst == M_BS || mst == M_BX) begin
            if (ux) begin
                mst = M_OWN; mown = uid; msh = '0; msh[uid] = 1;
            end else if (ub && mst == M_BS) begin
                mst = M_SH;
            end
        end else if (mst == M_W2) begin
            if (ub) msh[uid] = 1;
            if (cl) mdty = rsp_dirty;
            if (ub && cl) mst = M_SH;
            else if (ub) mst = M_WD;
            else if (cl) mst = M_WU;
        end else if (mst == M_WD) begin
            if (cl) begin mdty = rsp_dirty; mst = M_SH; end
        end else if (mst == M_WU) begin
            if (ub) begin msh[uid] = 1; mst = M_SH; end
        end
    endtask

    task automatic compare(string tag);
        string act, exp;
        act = $sformatf("dv%0b dx%0b dd%0d da%0d av%0b ad%0d ac%0d fv%0b fx%0b fd%0d fr%0d iv%0b im%h mf%0b wv%0b wd%0d rc%0b p%0d sh%h own%0d dt%0b",
            data_valid, data_excl, data_dest, int'($signed(data_ack)), ack_valid, ack_dest,
            int'($signed(ack_cnt)), fwd_valid, fwd_excl, fwd_dest, fwd_req, inv_valid, inv_mask,
            fetch_valid, wback_valid, wback_dest, recycle, perm, sharers, owner, dirty);
        exp = $sformatf("dv%0b dx%0b dd%0d da%0d av%0b ad%0d ac%0d fv%0b fx%0b fd%0d fr%0d iv%0b im%h mf%0b wv%0b wd%0d rc%0b p%0d sh%h own%0d dt%0b",
            e_dv, e_dx, e_dd, e_da, e_av, e_ad, e_ac, e_fv, e_fx, e_fd, e_fr, e_iv, e_im,
            e_mf, e_wv, e_wd, e_rc, perm_exp(mst), msh, mown, mdty);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual [%s] expected [%s]", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_hit = 0; req_type = 0; req_id = 0; req_dirty = 0;
        rsp_valid = 0; rsp_mem = 0; rsp_dirty = 0;
        unblk_valid = 0; unblk_excl = 0; unblk_id = 0;
    endtask

    task automatic tick(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        idle_inputs();
    endtask

    task automatic do_reset(string tag);
        idle_inputs();
        rst_n = 0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        compare(tag);
    endtask

    task automatic req(string tag, int t, int id, bit d = 0, bit hit = 1);
        req_valid = 1; req_hit = hit; req_type = 3'(t); req_id = 2'(id); req_dirty = d;
        tick(tag);
    endtask

    task automatic rsp(string tag, bit from_mem, bit d);
        rsp_valid = 1; rsp_mem = from_mem; rsp_dirty = d;
        tick(tag);
    endtask

    task automatic unb(string tag, bit x, int id);
        unblk_valid = 1; unblk_excl = x; unblk_id = 2'(id);
        tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        @(negedge clk);
        do_reset("R1 reset state");
        tick("R1 idle after reset");
        req("R13 request without hit", 0, 1, 0, 0);
        req("R7 writeback to not-present line", 4, 2, 1);
        req("R3 read miss fetch", 0, 1);
        req("R12 exclusive read during fetch", 2, 2);
        rsp("R4 client data ignored in fetch", 0, 1);
        rsp("R4 memory data for read", 1, 0);
        unb("R10 exclusive unblock", 1, 1);
        req("R9 read forwarded to owner", 0, 3);
        req("R12 read while waiting", 0, 2);
        unb("R9 unblock before data", 0, 3);
        rsp("R9 owner data after unblock", 0, 1);
        req("R5 read in shared", 0, 0);
        unb("R11 plain unblock", 0, 0);
        req("R6 upgrade from sharer", 3, 1);
        unb("R10 exclusive unblock after upgrade", 1, 1);
        req("R7 stale writeback in owned state", 4, 3, 0);
        req("R7 owner writeback", 4, 1, 1);
        req("R8 read in bank-modified", 0, 2);
        unb("R10 exclusive unblock from bank-modified", 1, 2);
        req("R9 exclusive read forwarded", 2, 0);
        unb("R10 new owner", 1, 0);
        req("R9 instruction read forwarded", 1, 3);
        rsp("R9 owner data first", 0, 0);
        unb("R9 unblock second", 0, 3);
        req("R5 exclusive read from sharer", 2, 3);
        unb("R10 owner after shared exclusive read", 1, 3);
        req("R9 read forwarded again", 0, 1);
        unblk_valid = 1; unblk_excl = 0; unblk_id = 2'd1;
        rsp_valid = 1; rsp_mem = 0; rsp_dirty = 1;
        tick("R9 data and unblock same cycle");
        req("R6 upgrade from non-sharer acts as exclusive read", 3, 2);
        unb("R11 unblock after exclusive read", 0, 2);
        req("R7 writeback from sharer in shared state", 4, 1, 1);
        req("R13 unknown type ignored", 6, 0);
        do_reset("R1 second reset");
        req("R3 instruction read miss", 1, 2);
        rsp("R4 memory data for instruction read", 1, 1);
        req("R12 upgrade while blocked", 3, 2);
        unb("R11 unblock after instruction fill", 0, 2);
        req("R2 read-only state read", 0, 1);
        unb("R11 unblock", 0, 1);
        do_reset("R1 third reset");
        req("R3 exclusive read miss", 2, 1);
        rsp("R4 memory data for exclusive read", 1, 0);
        req("R7 writeback while blocked", 4, 1, 1);
        unb("R10 exclusive unblock after fill", 1, 1);
        req("R7 owner writeback clean", 4, 1, 0);
        req("R8 instruction read in bank-modified", 1, 3);
        unb("R11 unblock after instruction read", 0, 3);
        req("R5 exclusive read lone sharer", 2, 3);
        unb("R10 owner again", 1, 3);
        req("R7 writeback dirty", 4, 3, 1);
        req("R8 exclusive read in bank-modified", 2, 0);
        unb("R11 plain unblock ignored when exclusive expected", 0, 0);
        unb("R10 final exclusive unblock", 1, 0);
        tick("R2 idle in owned state");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule